// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two access ports of a shared 1K x 8 memory, called left and right. Each port has an enable, a write strobe and a 10-bit address. The block flags the cycles in which both ports are enabled on the same location. It is synchronous: each port's request is captured every clock, so it knows which side has been waiting on its current address and which side has just arrived.

On a collision, the port that was already present keeps the location. The other port sees its active-low busy output go low. If both ports arrive in the same cycle, the left port wins. The block also drives a write-permit signal for each port, which the memory array uses to gate writes. A port that is held busy has its write dropped without notice, whatever its strobe says.

The grant does not change while the collision lasts. It is released in the same cycle that the addresses part or either enable falls. A blocked port must treat read data as invalid until its busy output returns high.

Top module: `dpcol_arbiter`

## Requirements
- R1: A busy output goes low only when both enables are high and the two full-width addresses are equal. Otherwise both busy outputs are high.
- R2: A collision is new when the ports were not colliding in the previous cycle. When it starts, a port counts as "already present" if it was enabled on the same address in the previous cycle. If only one port is already present, that port wins and the other port's busy goes low in that same cycle.
- R3: The two busy outputs are never low together.
- R4: If neither port, or both ports, were already present when a new collision starts, the left port wins and the right busy output goes low.
- R5: The write permit for a port equals that port's enable AND its write strobe AND its busy output. A busy port therefore never receives a write permit.
- R6: In the same cycle that the addresses differ or either enable is low, both busy outputs return high.
- R7: While the collision continues from one cycle to the next, the winner does not change, and neither busy output changes level.
- R8: While the synchronous active-high reset is asserted, both busy outputs are high. Reset also clears all request history. In the first cycle after reset, a collision therefore falls under R4, even if it was present before and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_en | input | 1 | Left port enable |
| lt_wr | input | 1 | Left port write strobe |
| lt_addr | input | ADDR_W | Left port address |
| rt_en | input | 1 | Right port enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_addr | input | ADDR_W | Right port address |
| lt_busy_n | output | 1 | Left busy, active low |
| rt_busy_n | output | 1 | Right busy, active low |
| lt_wr_ok | output | 1 | Left write permit to the array |
| rt_wr_ok | output | 1 | Right write permit to the array |

## Verification
The bench builds the block with the default address width of 10 bits. This makes the top mailbox-style location 0x3FF reachable. It also allows a pair of addresses that differ only in the lowest bit (0x3FE and 0x3FF), which the comparison must reject. The sequences cover three kinds of collision start: left arriving first, right arriving first, and both arriving in the same cycle. They also cover release by an address change and release by an enable dropping. Finally, a reset is applied in the middle of a collision, and the bench checks that the history is cleared so that the left port wins afterwards.

// File: rtl/dpcol_pkg.sv
package dpcol_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Winner of a fresh collision: the side that was already present wins.
  // Both present or neither present falls to the left side.
  function automatic owner_e pick_first(input logic l_present, input logic r_present);
    if (r_present && !l_present) return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

  // Busy (active low) for a side, given the current owner.
  function automatic logic busy_n_for(input owner_e own, input logic is_left);
    if (is_left) return !(own == OWN_RIGHT);
    return !(own == OWN_LEFT);
  endfunction

endpackage

// File: rtl/dpcol_port_track.sv
module dpcol_port_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              present
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // Request unchanged since last cycle: this side was here first.
  assign present = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpcol_match.sv
module dpcol_match #(
  parameter int ADDR_W = 10
) (
  input  logic              en_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              hit
);
  assign hit = en_l && en_r && (addr_l == addr_r);
endmodule

// File: rtl/dpcol_grant.sv
module dpcol_grant
  import dpcol_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hit,
  input  logic   l_present,
  input  logic   r_present,
  output owner_e owner
);
  owner_e owner_q;

  always_comb begin
    if (rst || !hit)            owner = OWN_NONE;
    else if (owner_q != OWN_NONE) owner = owner_q;
    else                        owner = pick_first(l_present, r_present);
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner;
  end
endmodule

// File: rtl/dpcol_arbiter.sv
module dpcol_arbiter
  import dpcol_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lt_en,
  input  logic              lt_wr,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              rt_en,
  input  logic              rt_wr,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lt_busy_n,
  output logic              rt_busy_n,
  output logic              lt_wr_ok,
  output logic              rt_wr_ok
);
  localparam int NPORT = 2;

  logic              en_v      [NPORT];
  logic [ADDR_W-1:0] addr_v    [NPORT];
  logic              present_v [NPORT];

  logic   hit_w;
  logic   l_present_w;
  logic   r_present_w;
  owner_e owner_w;

  assign en_v[0]   = lt_en;
  assign en_v[1]   = rt_en;
  assign addr_v[0] = lt_addr;
  assign addr_v[1] = rt_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    dpcol_port_track #(.ADDR_W(ADDR_W)) trk_i (
      .clk     (clk),
      .rst     (rst),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .present (present_v[p])
    );
  end

  assign l_present_w = present_v[0];
  assign r_present_w = present_v[1];

  dpcol_match #(.ADDR_W(ADDR_W)) match_i (
    .en_l   (lt_en),
    .en_r   (rt_en),
    .addr_l (lt_addr),
    .addr_r (rt_addr),
    .hit    (hit_w)
  );

  dpcol_grant grant_i (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit_w),
    .l_present (l_present_w),
    .r_present (r_present_w),
    .owner     (owner_w)
  );

  assign lt_busy_n = busy_n_for(owner_w, 1'b1);
  assign rt_busy_n = busy_n_for(owner_w, 1'b0);
  assign lt_wr_ok  = lt_en && lt_wr && lt_busy_n;
  assign rt_wr_ok  = rt_en && rt_wr && rt_busy_n;
endmodule

// File: rtl/dpcol_checker.sv
module dpcol_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              lt_en,
  input logic              rt_en,
  input logic [ADDR_W-1:0] lt_addr,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              lt_busy_n,
  input logic              rt_busy_n,
  input logic              lt_wr_ok,
  input logic              rt_wr_ok,
  input logic              hit_w,
  input logic              l_present_w,
  input logic              r_present_w
);
  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (rst)
    (!lt_busy_n || !rt_busy_n) |-> (lt_en && rt_en && lt_addr == rt_addr));

  a_r2_right_late_loses: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_w && !$past(hit_w) && l_present_w && !r_present_w) |-> !rt_busy_n);

  a_r2_left_late_loses: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_w && !$past(hit_w) && r_present_w && !l_present_w) |-> !lt_busy_n);

  a_r3_never_both_busy: assert property (@(posedge clk) disable iff (rst)
    !(!lt_busy_n && !rt_busy_n));

  a_r5_left_no_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    !lt_busy_n |-> !lt_wr_ok);

  a_r5_right_no_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    !rt_busy_n |-> !rt_wr_ok);

  a_r7_grant_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_w && $past(hit_w)) |-> ($stable(lt_busy_n) && $stable(rt_busy_n)));

  a_r8_reset_idle: assert property (@(posedge clk)
    rst |-> (lt_busy_n && rt_busy_n));
endmodule

bind dpcol_arbiter dpcol_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .lt_en       (lt_en),
  .rt_en       (rt_en),
  .lt_addr     (lt_addr),
  .rt_addr     (rt_addr),
  .lt_busy_n   (lt_busy_n),
  .rt_busy_n   (rt_busy_n),
  .lt_wr_ok    (lt_wr_ok),
  .rt_wr_ok    (rt_wr_ok),
  .hit_w       (hit_w),
  .l_present_w (l_present_w),
  .r_present_w (r_present_w)
);

// File: tb/dpcol_arbiter_tb.sv
module dpcol_arbiter_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lt_en = 0, lt_wr = 0, rt_en = 0, rt_wr = 0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok;

  always #5 clk = ~clk;

  dpcol_arbiter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .lt_en(lt_en), .lt_wr(lt_wr), .lt_addr(lt_addr),
    .rt_en(rt_en), .rt_wr(rt_wr), .rt_addr(rt_addr),
    .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
    .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok)
  );

  typedef struct {
    logic  lb, rb, lw, rw;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event item_ev;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // Driver: one cycle per call; expected busy given, write permits derived
  // here from R5 (enable AND strobe AND busy-high).
  task automatic step(input logic r, input logic le, input logic lw, input logic [AW-1:0] la,
                      input logic re, input logic rw, input logic [AW-1:0] ra,
                      input logic elb, input logic erb, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; lt_en = le; lt_wr = lw; lt_addr = la;
    rt_en = re; rt_wr = rw; rt_addr = ra;
    e.lb = elb; e.rb = erb;
    e.lw = le && lw && elb;
    e.rw = re && rw && erb;
    e.tag = tag;
    exp_q.push_back(e);
    #2;
    -> item_ev;
  endtask

  // Monitor: pops each expected item and compares the ports.
  initial begin
    forever begin
      @(item_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if ({lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok} !== {e.lb, e.rb, e.lw, e.rw}) begin
          n_fail++;
          $display("FAIL %s: got lb=%b rb=%b lw=%b rw=%b expected lb=%b rb=%b lw=%b rw=%b",
                   e.tag, lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok, e.lb, e.rb, e.lw, e.rw);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(1, 0,0,10'h000, 0,0,10'h000, 1,1, "R8 reset idle");
    step(1, 1,1,10'h005, 1,1,10'h005, 1,1, "R8 busy high during reset with match");
    step(0, 1,1,10'h005, 0,0,10'h000, 1,1, "R1 left alone");
    step(0, 1,1,10'h005, 1,1,10'h006, 1,1, "R1 different addresses");
    step(0, 1,1,10'h005, 1,1,10'h005, 1,0, "R2 right arrives late, R5 right write dropped");
    step(0, 1,1,10'h005, 1,1,10'h005, 1,0, "R7 left grant held");
    step(0, 1,1,10'h005, 1,1,10'h007, 1,1, "R6 release on address change");
    step(0, 1,1,10'h007, 1,1,10'h007, 0,1, "R2 left arrives late, R5 left write dropped");
    step(0, 1,0,10'h007, 1,1,10'h007, 0,1, "R7 right grant held");
    step(0, 1,1,10'h007, 0,1,10'h007, 1,1, "R6 release on right enable low");
    step(0, 0,0,10'h000, 0,0,10'h000, 1,1, "R1 both idle");
    step(0, 1,1,10'h3FF, 1,1,10'h3FF, 1,0, "R4 same-cycle arrival left wins");
    step(0, 1,1,10'h3FF, 1,1,10'h3FF, 1,0, "R3 R7 hold after tie");
    step(0, 0,1,10'h3FF, 1,1,10'h3FF, 1,1, "R6 release on left enable low");
    step(0, 1,1,10'h3FE, 1,1,10'h3FF, 1,1, "R1 low-bit difference no collision");
    step(0, 0,1,10'h009, 1,1,10'h009, 1,1, "R1 left disabled same address");
    step(0, 0,0,10'h000, 1,1,10'h010, 1,1, "R1 right alone");
    step(0, 1,1,10'h010, 1,1,10'h010, 0,1, "R2 right first wins");
    step(1, 1,1,10'h010, 1,1,10'h010, 1,1, "R8 reset mid collision");
    step(1, 1,1,10'h010, 1,1,10'h010, 1,1, "R8 reset held");
    step(0, 1,1,10'h010, 1,1,10'h010, 1,0, "R8 history cleared left wins");
    step(0, 1,1,10'h010, 1,1,10'h010, 1,0, "R7 hold after reset");
    step(0, 0,0,10'h000, 0,0,10'h000, 1,1, "R6 both drop");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule